// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator with Bypass

This block gathers a set of level-sensitive interrupt sources, grouped into banks of 32, and folds them onto a small number of parent interrupt lines. Each bank has one enable word, one live status word and one forward word. Each parent line has its own routing word per bank. A parent line rises when a source is pending, enabled and selected by that parent's routing word. Parent lines are registered and follow their inputs one clock later.

Some sources must reach the next level without passing through the controller. Setting a source's forward bit sends its raw level straight to a dedicated bypass output. It also removes the source from the status word, the parent lines and the wake line. A registered wake output reports that any enabled source is pending.

Software reaches every word through a flat register port. The port has a combinational read and a write strobe, and it offers no set or clear aliases. Enable bits change only through a read-modify-write of the whole word. Bit positions with no source wired to them are tied off by a parameter.

Top module: `irq_agg_top`

## Requirements
- R1: After reset, every enable, forward and routing word reads zero. The parent outputs, the wake output and the bypass output stay low even when all sources are high.
- R2: The enable word of bank b sits at byte address b*0x10. Bank 0 holds sources 0..31 and bank 1 holds sources 32..63. A write replaces the whole word, so bits written as 0 are cleared. No address sets or clears individual bits.
- R3: The status word of bank b sits at b*0x10+0x4. It reads the live level of each connected, non-forwarded source. It has no read side effect, and writes to it change nothing.
- R4: The routing word for parent p and bank b sits at 0x100+4*(p*NUM_BANKS+b), so the order is parent 0 bank 0, parent 0 bank 1, parent 1 bank 0, and so on. Parent p goes high one clock after some source is pending, enabled and selected by one of its routing words.
- R5: A source whose forward bit is set appears on its bypass output bit in the same cycle, unregistered. It is absent from the status word, the parent outputs and the wake output.
- R6: The forward word of bank b sits at b*0x10+0x8 and reads back what was written to its connected bits.
- R7: Bit positions not marked in SRC_PRESENT read zero in the status, enable, forward and routing words, and they never raise a parent, bypass or wake output. The default leaves bits 28..31 of each bank unconnected.
- R8: The wake output goes high one clock after any enabled, non-forwarded source is pending, and it stays low when the pending sources are disabled.
- R9: Addresses outside the map read zero, and writes to them leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register byte address |
| regWrEn | input | 1 | Write strobe for the current address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data |
| srcIn | input | NUM_BANKS*32 | Level interrupt sources |
| parentIrq | output | NUM_PARENTS | Registered parent interrupt lines |
| bypassIrq | output | NUM_BANKS*32 | Forwarded raw source levels |
| wakeIrq | output | 1 | Registered wake request |

## Verification
Sources are raised one at a time in each bank. The bench checks the parent lines both before and after the clock edge, which separates the one-cycle latency from a combinational path. It also separates bank 0 from bank 1 and parent 0 from parent 1. Routing words are written at the parent 0 bank 1 and parent 1 bank 0 slots so that a swapped index order shows up as the wrong parent rising. A source that is enabled and routed is then forwarded, which tells the bypass path apart from the aggregation path. Sources on unconnected positions, disabled sources, all-ones writes and writes to the status and unmapped addresses show whether tie-offs and read-only words hold.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int STB_IDX_W = 8;

  typedef enum logic [2:0] {
    REG_NONE    = 3'd0,
    REG_ENABLE  = 3'd1,
    REG_STATUS  = 3'd2,
    REG_FORWARD = 3'd3,
    REG_ROUTE   = 3'd4
  } regKind_e;

  // Strobe bundle from address decode to the register datapath
  typedef struct packed {
    logic                 wrStb;
    regKind_e             kind;
    logic [STB_IDX_W-1:0] idx;
  } regStb_t;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int NUM_PARENTS = 2,
  parameter int ADDR_W      = 12,
  parameter int ROUTE_BASE  = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStb_t           stb
);
  localparam int NUM_ROUTES = NUM_PARENTS * NUM_BANKS;
  localparam int BANK_SPAN  = NUM_BANKS * 16;
  localparam int ROUTE_END  = ROUTE_BASE + 4 * NUM_ROUTES;

  logic [31:0] addrW;
  assign addrW = 32'(regAddr);

  always_comb begin
    stb = '0;
    if (addrW < 32'(BANK_SPAN)) begin
      stb.idx = STB_IDX_W'(addrW >> 4);
      case (addrW[3:2])
        2'd0:    stb.kind = REG_ENABLE;
        2'd1:    stb.kind = REG_STATUS;
        2'd2:    stb.kind = REG_FORWARD;
        default: stb.kind = REG_NONE;
      endcase
    end else if (addrW >= 32'(ROUTE_BASE) && addrW < 32'(ROUTE_END)) begin
      stb.kind = REG_ROUTE;
      stb.idx  = STB_IDX_W'((addrW - 32'(ROUTE_BASE)) >> 2);
    end
    stb.wrStb = regWrEn && (stb.kind == REG_ENABLE || stb.kind == REG_FORWARD ||
                            stb.kind == REG_ROUTE);
  end

  AST_ROUTE_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == REG_ROUTE |-> 32'(stb.idx) < 32'(NUM_ROUTES)); // R4
  AST_BANK_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.kind == REG_ENABLE || stb.kind == REG_FORWARD) |-> 32'(stb.idx) < 32'(NUM_BANKS)); // R2
endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int BANK_W      = 32,
  parameter int NUM_PARENTS = 2,
  parameter logic [NUM_BANKS*BANK_W-1:0] SRC_PRESENT = {NUM_BANKS{32'h0FFF_FFFF}},
  parameter bit HAS_WAKE    = 1'b1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStb_t                       stb,
  input  logic [BANK_W-1:0]             wrData,
  output logic [BANK_W-1:0]             rdData,
  input  logic [NUM_BANKS*BANK_W-1:0]   srcIn,
  output logic [NUM_PARENTS-1:0]        parentIrq,
  output logic [NUM_BANKS*BANK_W-1:0]   bypassIrq,
  output logic                          wakeIrq
);
  localparam int NUM_SRC     = NUM_BANKS * BANK_W;
  localparam int NUM_ROUTES  = NUM_PARENTS * NUM_BANKS;
  localparam int BANK_IDX_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ROUTE_IDX_W = (NUM_ROUTES > 1) ? $clog2(NUM_ROUTES) : 1;

  logic [BANK_W-1:0] enReg    [NUM_BANKS];
  logic [BANK_W-1:0] fwdReg   [NUM_BANKS];
  logic [BANK_W-1:0] routeReg [NUM_ROUTES];

  logic [NUM_SRC-1:0]                  enFlat;
  logic [NUM_SRC-1:0]                  fwdFlat;
  logic [NUM_SRC-1:0]                  statusVec;
  logic [NUM_SRC-1:0]                  pendEn;
  logic [NUM_PARENTS-1:0][NUM_SRC-1:0] routeFlat;

  // Per-bank enable and forward words
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BANK_W-1:0] BANK_MASK = SRC_PRESENT[b*BANK_W +: BANK_W];
    logic bankHit;
    assign bankHit = stb.wrStb && (stb.idx == STB_IDX_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg[b]  <= '0;
        fwdReg[b] <= '0;
      end else if (bankHit) begin
        if (stb.kind == REG_ENABLE)  enReg[b]  <= wrData & BANK_MASK;
        if (stb.kind == REG_FORWARD) fwdReg[b] <= wrData & BANK_MASK;
      end
    end

    assign enFlat[b*BANK_W +: BANK_W]  = enReg[b];
    assign fwdFlat[b*BANK_W +: BANK_W] = fwdReg[b];
  end

  // Routing words, ordered parent-major then bank
  for (genvar p = 0; p < NUM_PARENTS; p++) begin : g_par
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rb
      localparam int RIDX = p * NUM_BANKS + b;
      localparam logic [BANK_W-1:0] BANK_MASK = SRC_PRESENT[b*BANK_W +: BANK_W];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          routeReg[RIDX] <= '0;
        end else if (stb.wrStb && stb.kind == REG_ROUTE && stb.idx == STB_IDX_W'(RIDX)) begin
          routeReg[RIDX] <= wrData & BANK_MASK;
        end
      end

      assign routeFlat[p][b*BANK_W +: BANK_W] = routeReg[RIDX];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) parentIrq[p] <= 1'b0;
      else       parentIrq[p] <= |(pendEn & routeFlat[p]);
    end

    AST_PARENT_NEEDS_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
      parentIrq[p] |-> $past(|(routeFlat[p] & enFlat))); // R4
    AST_PARENT_NOT_FWD: assert property (@(posedge clk) disable iff (!rstN)
      parentIrq[p] |-> $past(|(srcIn & ~fwdFlat & SRC_PRESENT))); // R5
  end

  // Live status and bypass paths
  assign statusVec = srcIn & ~fwdFlat & SRC_PRESENT;
  assign bypassIrq = srcIn & fwdFlat & SRC_PRESENT;
  assign pendEn    = statusVec & enFlat;

  if (HAS_WAKE) begin : g_wake
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wakeIrq <= 1'b0;
      else       wakeIrq <= |pendEn;
    end
  end else begin : g_nowake
    assign wakeIrq = 1'b0;
  end

  // Read mux
  logic [BANK_IDX_W-1:0]  bankSel;
  logic [ROUTE_IDX_W-1:0] routeSel;
  assign bankSel  = stb.idx[BANK_IDX_W-1:0];
  assign routeSel = stb.idx[ROUTE_IDX_W-1:0];

  always_comb begin
    rdData = '0;
    case (stb.kind)
      REG_ENABLE:  rdData = enReg[bankSel];
      REG_FORWARD: rdData = fwdReg[bankSel];
      REG_STATUS:  rdData = statusVec[32'(bankSel)*BANK_W +: BANK_W];
      REG_ROUTE:   rdData = routeReg[routeSel];
      default:     rdData = '0;
    endcase
  end

  AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> $past(|enFlat)); // R8
  AST_UNUSED_EN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (enFlat & ~SRC_PRESENT) == '0 && (fwdFlat & ~SRC_PRESENT) == '0); // R7
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == REG_STATUS |=> $stable(enFlat) && $stable(fwdFlat)); // R3
  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.kind == REG_NONE |=> $stable(enFlat) && $stable(fwdFlat) && $stable(routeFlat)); // R9
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int NUM_PARENTS = 2,
  parameter int ADDR_W      = 12,
  parameter int ROUTE_BASE  = 'h100,
  parameter logic [NUM_BANKS*32-1:0] SRC_PRESENT = {NUM_BANKS{32'h0FFF_FFFF}},
  parameter bit HAS_WAKE    = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic                     regWrEn,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  input  logic [NUM_BANKS*32-1:0]  srcIn,
  output logic [NUM_PARENTS-1:0]   parentIrq,
  output logic [NUM_BANKS*32-1:0]  bypassIrq,
  output logic                     wakeIrq
);
  regStb_t stb;

  irq_agg_decode #(
    .NUM_BANKS(NUM_BANKS), .NUM_PARENTS(NUM_PARENTS),
    .ADDR_W(ADDR_W), .ROUTE_BASE(ROUTE_BASE)
  ) decode_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .stb(stb)
  );

  irq_agg_datapath #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(32), .NUM_PARENTS(NUM_PARENTS),
    .SRC_PRESENT(SRC_PRESENT), .HAS_WAKE(HAS_WAKE)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .rdData(regRdData),
    .srcIn(srcIn), .parentIrq(parentIrq), .bypassIrq(bypassIrq), .wakeIrq(wakeIrq)
  );
endmodule

// File: tb/irq_agg_top_tb.sv
module irq_agg_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [63:0] srcIn = '0;
  logic [1:0]  parentIrq;
  logic [63:0] bypassIrq;
  logic        wakeIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_agg_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .srcIn(srcIn),
    .parentIrq(parentIrq), .bypassIrq(bypassIrq), .wakeIrq(wakeIrq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b0;
    #1 d = regRdData;
  endtask

  task automatic testReset();
    logic [31:0] d;
    srcIn = '1;
    repeat (2) @(negedge clk);
    chk("R1 parent", 64'(parentIrq), 0);
    chk("R1 wake", 64'(wakeIrq), 0);
    chk("R1 bypass", bypassIrq, 0);
    regRead(12'h000, d); chk("R1 enable0", 64'(d), 0);
    regRead(12'h018, d); chk("R1 forward1", 64'(d), 0);
    regRead(12'h10C, d); chk("R1 route3", 64'(d), 0);
    srcIn = '0;
  endtask

  task automatic testEnable();
    logic [31:0] d;
    regWrite(12'h000, 32'h0000_00F0);
    regRead(12'h000, d); chk("R2 enable0 write", 64'(d), 64'hF0);
    regWrite(12'h000, 32'h0000_0010);
    regRead(12'h000, d); chk("R2 whole-word replace", 64'(d), 64'h10);
    regWrite(12'h010, 32'hFFFF_FFFF);
    regRead(12'h010, d); chk("R7 enable1 unused bits", 64'(d), 64'h0FFF_FFFF);
  endtask

  task automatic testStatus();
    logic [31:0] d;
    srcIn = 64'h1234_5678_9ABC_DEF0;
    regRead(12'h004, d); chk("R3 status0", 64'(d), 64'h0ABC_DEF0);
    regRead(12'h014, d); chk("R3 status1", 64'(d), 64'h0234_5678);
    regWrite(12'h004, 32'hFFFF_FFFF);
    regRead(12'h000, d); chk("R3 status write no effect on enable", 64'(d), 64'h10);
    regRead(12'h004, d); chk("R3 status after write", 64'(d), 64'h0ABC_DEF0);
    srcIn = '0;
  endtask

  task automatic testRouting();
    regWrite(12'h100, 32'h10);  // parent0 bank0
    regWrite(12'h10C, 32'h01);  // parent1 bank1
    @(negedge clk); srcIn = 64'h10;
    #1 chk("R4 parent before edge", 64'(parentIrq), 0);
    @(negedge clk); chk("R4 parent0 bank0", 64'(parentIrq), 2'b01);
    srcIn = 64'h1_0000_0000;
    @(negedge clk); chk("R4 parent1 bank1", 64'(parentIrq), 2'b10);
    srcIn = 64'h20;
    @(negedge clk); chk("R4 disabled source", 64'(parentIrq), 0);
    srcIn = '0;
    regWrite(12'h108, 32'h10);  // parent1 bank0
    regWrite(12'h104, 32'h00);  // parent0 bank1
    @(negedge clk); srcIn = 64'h10;
    @(negedge clk); chk("R4 order parent1 bank0", 64'(parentIrq), 2'b11);
    srcIn = 64'h1_0000_0000;
    @(negedge clk); chk("R4 order parent0 bank1 clear", 64'(parentIrq), 2'b10);
    srcIn = '0;
    @(negedge clk);
  endtask

  task automatic testForward();
    logic [31:0] d;
    regWrite(12'h008, 32'h10);
    regRead(12'h008, d); chk("R6 forward0 readback", 64'(d), 64'h10);
    @(negedge clk); srcIn = 64'h10;
    #1 chk("R5 bypass same cycle", bypassIrq, 64'h10);
    @(negedge clk);
    chk("R5 forwarded no parent", 64'(parentIrq), 0);
    chk("R5 forwarded no wake", 64'(wakeIrq), 0);
    regRead(12'h004, d); chk("R5 forwarded no status", 64'(d), 0);
    srcIn = '0;
    #1 chk("R5 bypass follows low", bypassIrq, 0);
    regWrite(12'h008, 32'h0);
  endtask

  task automatic testUnused();
    logic [31:0] d;
    regWrite(12'h000, 32'hFFFF_FFFF);
    regWrite(12'h100, 32'hFFFF_FFFF);
    regWrite(12'h008, 32'hF000_0000);
    regRead(12'h008, d); chk("R7 forward unused", 64'(d), 0);
    regRead(12'h100, d); chk("R7 route unused", 64'(d), 64'h0FFF_FFFF);
    @(negedge clk); srcIn = 64'h4000_0000;
    @(negedge clk);
    chk("R7 unused no parent", 64'(parentIrq), 0);
    chk("R7 unused no bypass", bypassIrq, 0);
    chk("R7 unused no wake", 64'(wakeIrq), 0);
    regRead(12'h004, d); chk("R7 unused status", 64'(d), 0);
    srcIn = '0;
  endtask

  task automatic testWake();
    @(negedge clk); srcIn = 64'h2;
    #1 chk("R8 wake before edge", 64'(wakeIrq), 0);
    @(negedge clk); chk("R8 wake asserted", 64'(wakeIrq), 1);
    srcIn = '0;
    regWrite(12'h000, 32'h0);
    regWrite(12'h010, 32'h0);
    @(negedge clk); srcIn = 64'h2;
    @(negedge clk); chk("R8 wake disabled source", 64'(wakeIrq), 0);
    srcIn = '0;
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    regWrite(12'h010, 32'h0000_0ABC);
    regWrite(12'h080, 32'hFFFF_FFFF);
    regWrite(12'h00C, 32'hFFFF_FFFF);
    regRead(12'h080, d); chk("R9 unmapped read", 64'(d), 0);
    regRead(12'h00C, d); chk("R9 hole read", 64'(d), 0);
    regRead(12'h010, d); chk("R9 enable1 intact", 64'(d), 64'hABC);
    regRead(12'h008, d); chk("R9 forward0 intact", 64'(d), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testEnable();
    testStatus();
    testRouting();
    testForward();
    testUnused();
    testWake();
    testUnmapped();
    finishRun();
  end
endmodule